// File: doc/BRIEF.md
# Byte FIFO with Water-Level Alerts

This block is a 64-deep byte queue placed between a host-side register port and an internal codec. One side writes bytes through a push strobe and the other side reads them through a pop strobe. Bytes leave in the order they arrived. A byte written in one cycle can be popped in the next, so a consumer can start as soon as one byte is present.

The block keeps a 7-bit occupancy count, so the full value 64 can be shown. It also drives two alert flags against one programmable margin, `water_mark`. The low alert tells a refilling agent that the queue is nearly drained. The high alert tells a draining agent that the queue is nearly full. Both alerts are registered and go to an interrupt aggregator outside this block.

A push into a full queue is discarded and sets a sticky overflow flag. A pop from an empty queue returns zero. A flush strobe empties the queue in one cycle.

Top module: `wlf_fifo`

## Requirements
- R1: While `rst` is high, and after it is released with no traffic, `fill_count` is 0, `lo_alert` is 1, `hi_alert` is 0, `ovf_err` is 0 and `pop_data` is 0x00.
- R2: Bytes are popped in the order they were pushed. `fill_count` (7 bits, range 0..64) rises by one for each accepted push and falls by one for each accepted pop.
- R3: A push while `fill_count` is 64 and no pop is issued is discarded. The stored bytes are left untouched and `ovf_err` goes to 1 on the next cycle. It stays at 1 until a flush or a reset.
- R4: A pop while `fill_count` is 0 makes `pop_data` read 0x00 on the next cycle and leaves `fill_count` unchanged, apart from any push in the same cycle.
- R5: A push and a pop in the same cycle with `fill_count` between 1 and 64 leave `fill_count` unchanged. Both transfers take effect, even when the queue is full.
- R6: `flush` takes priority over push and pop. On the next cycle, `fill_count` is 0, the queue is empty, `ovf_err` is 0 and `pop_data` is 0x00.
- R7: After each clock edge, `lo_alert` is 1 exactly when the new `fill_count` is at most the `water_mark` value sampled at that edge.
- R8: After each clock edge, `hi_alert` is 1 exactly when the new `fill_count` is at least 64 minus the `water_mark` value sampled at that edge.
- R9: The popped byte appears on `pop_data` on the cycle after the pop strobe. It holds its value until the next pop or flush. A byte pushed in cycle N can be popped in cycle N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Empty the queue in one cycle |
| push_en | input | 1 | Write strobe |
| push_data | input | 8 | Byte to write |
| pop_en | input | 1 | Read strobe |
| pop_data | output | 8 | Registered read byte |
| water_mark | input | 6 | Alert margin, 0..63 |
| fill_count | output | 7 | Bytes held, 0..64 |
| lo_alert | output | 1 | Count at or below the margin |
| hi_alert | output | 1 | Count at or above 64 minus the margin |
| ovf_err | output | 1 | Sticky: a push was discarded while full |

## Verification
A pointer that drifts away from the count shows at the ports as wrong or reordered bytes. These appear on `pop_data` one cycle after the affected pop. A wrong count shows at once on `fill_count` and, through the alerts, on the same cycle. The bench keeps a byte queue as a scoreboard and checks every popped byte against it. It also checks the count and both alert flags after every edge. The runs cover a full-queue wrap, a discarded push, empty pops, combined push and pop at both ends, and water marks of 0, 8 and 32.

// File: rtl/wlf_pkg.sv
package wlf_pkg;
  // per-cycle transfer decision shared by control and storage
  typedef struct packed {
    logic wr_ok;   // push accepted
    logic rd_ok;   // pop accepted (queue non-empty)
    logic rd_nul;  // pop on empty queue: present zero
  } xfer_t;
endpackage

// File: rtl/wlf_store.sv
module wlf_store #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  wlf_pkg::xfer_t xf,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // write port, no reset so the array maps to block RAM
  always_ff @(posedge clk) begin
    if (xf.wr_ok) mem[waddr] <= wdata;
  end

  // registered read port with synchronous clear of the output register
  always_ff @(posedge clk) begin
    if (rst || clr)     rdata <= '0;
    else if (xf.rd_ok)  rdata <= mem[raddr];
    else if (xf.rd_nul) rdata <= '0;
  end

  // R4: an empty pop yields a zero byte
  a_r4_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
    (xf.rd_nul && !clr) |=> (rdata == '0));
endmodule

// File: rtl/wlf_ctrl.sv
module wlf_ctrl #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_en,
  input  logic          pop_en,
  output wlf_pkg::xfer_t xf,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic full, empty;
  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);

  always_comb begin
    xf.rd_ok  = !flush && pop_en && !empty;
    xf.rd_nul = !flush && pop_en && empty;
    xf.wr_ok  = !flush && push_en && (!full || pop_en);
  end

  always_comb begin
    cnt_nxt = cnt;
    if (flush) cnt_nxt = '0;
    else if (xf.wr_ok && !xf.rd_ok) cnt_nxt = cnt + 1'b1;
    else if (!xf.wr_ok && xf.rd_ok) cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (xf.wr_ok) wptr <= wptr + 1'b1;
      if (xf.rd_ok) rptr <= rptr + 1'b1;
      if (push_en && !xf.wr_ok) ovf <= 1'b1;
    end
  end

  // R2: occupancy never exceeds the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);
  // R3: a push into a full queue without a pop flags overflow and keeps the count
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push_en && !pop_en && full && !flush) |=> (ovf && cnt == FULL_CNT));
  // R4: an empty pop alone leaves the count at zero
  a_r4_empty_pop_count: assert property (@(posedge clk) disable iff (rst)
    (pop_en && !push_en && empty && !flush) |=> (cnt == '0));
  // R5: a combined push and pop on a non-empty queue holds the count
  a_r5_pair_holds: assert property (@(posedge clk) disable iff (rst)
    (push_en && pop_en && !empty && !flush) |=> $stable(cnt));
  // R6: flush empties the queue and clears the overflow flag
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt == '0 && !ovf));
endmodule

// File: rtl/wlf_alert.sv
module wlf_alert #(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  parameter int LW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [LW-1:0] level,
  output logic          lo,
  output logic          hi
);
  logic [CW-1:0] lvl_ext, hi_thr;
  assign lvl_ext = CW'(level);
  assign hi_thr  = CW'(DEPTH) - lvl_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= 1'b1;
      hi <= 1'b0;
    end else begin
      lo <= (cnt_nxt <= lvl_ext);
      hi <= (cnt_nxt >= hi_thr);
    end
  end
endmodule

// File: rtl/wlf_fifo.sv
module wlf_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_en,
  input  logic [DW-1:0] push_data,
  input  logic          pop_en,
  output logic [DW-1:0] pop_data,
  input  logic [AW-1:0] water_mark,
  output logic [CW-1:0] fill_count,
  output logic          lo_alert,
  output logic          hi_alert,
  output logic          ovf_err
);
  wlf_pkg::xfer_t xf;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_nxt;

  wlf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .push_en(push_en), .pop_en(pop_en),
    .xf(xf), .wptr(wptr), .rptr(rptr), .cnt(fill_count), .cnt_nxt(cnt_nxt),
    .ovf(ovf_err)
  );

  wlf_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .clr(flush), .xf(xf), .waddr(wptr), .wdata(push_data),
    .raddr(rptr), .rdata(pop_data)
  );

  wlf_alert #(.DEPTH(DEPTH), .CW(CW), .LW(AW)) u_alert (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .level(water_mark),
    .lo(lo_alert), .hi(hi_alert)
  );

  // R7: low alert follows the count against the margin sampled at the edge
  a_r7_lo_alert: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lo_alert == (fill_count <= CW'($past(water_mark)))));
  // R8: high alert follows the count against depth minus the margin
  a_r8_hi_alert: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hi_alert == (fill_count >= (CW'(DEPTH) - CW'($past(water_mark))))));
  // R6: flush returns a zero read register
  a_r6_flush_zero: assert property (@(posedge clk) disable iff (rst)
    flush |=> (pop_data == '0));
endmodule

// File: tb/wlf_fifo_bench.sv
module wlf_fifo_bench;
  logic       clk = 1'b0;
  logic       rst, flush, push_en, pop_en;
  logic [7:0] push_data, pop_data;
  logic [5:0] water_mark;
  logic [6:0] fill_count;
  logic       lo_alert, hi_alert, ovf_err;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  logic [7:0] sb_q [$];   // scoreboard: bytes expected to come out
  bit         m_ovf;
  logic [7:0] seq_byte = 8'h11;

  always #5 clk = ~clk;

  wlf_fifo u_wlf_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push_en(push_en), .push_data(push_data),
    .pop_en(pop_en), .pop_data(pop_data), .water_mark(water_mark),
    .fill_count(fill_count), .lo_alert(lo_alert), .hi_alert(hi_alert),
    .ovf_err(ovf_err)
  );

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compares the port state after an edge with the model
  task automatic monitor(bit popped, int pop_exp, string preq);
    int n = sb_q.size();
    if (popped) check(preq, pop_data, pop_exp);
    check("R2 count", fill_count, n);
    check("R7 lo_alert", lo_alert, (n <= water_mark) ? 1 : 0);
    check("R8 hi_alert", hi_alert, (n >= 64 - water_mark) ? 1 : 0);
    check("R3 ovf_err", ovf_err, m_ovf);
  endtask

  // driver: applies one cycle of stimulus and updates the scoreboard
  task automatic step(bit ps, bit pp, bit fl = 0);
    bit         popped = 0;
    int         pexp = 0;
    string      preq = "R9 pop order";
    logic [7:0] d = seq_byte;
    push_en = ps; pop_en = pp; flush = fl; push_data = d;
    if (ps) seq_byte = seq_byte + 8'h07;
    @(posedge clk);
    #1;
    if (fl) begin
      sb_q.delete();
      m_ovf = 0;
      popped = 1; pexp = 0; preq = "R6 flush zero";
    end else begin
      bit rd_ok = pp && sb_q.size() > 0;
      bit wr_ok = ps && (sb_q.size() < 64 || pp);
      if (pp) begin
        popped = 1;
        if (rd_ok) pexp = sb_q.pop_front();
        else begin pexp = 0; preq = "R4 empty pop"; end
      end
      if (wr_ok) sb_q.push_back(d);
      else if (ps) m_ovf = 1;
    end
    push_en = 0; pop_en = 0; flush = 0;
    monitor(popped, pexp, preq);
  endtask

  initial begin
    rst = 1; flush = 0; push_en = 0; pop_en = 0; push_data = 0; water_mark = 6'd8;
    m_ovf = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 count", fill_count, 0);
    check("R1 lo", lo_alert, 1);
    check("R1 hi", hi_alert, 0);
    check("R1 ovf", ovf_err, 0);
    check("R1 data", pop_data, 0);
    rst = 0;
    step(0, 0);
    check("R1 idle lo", lo_alert, 1);

    // R9: push then pop on the very next cycle
    step(1, 0);
    step(0, 1);
    // R4: empty pop, and empty pop with push
    step(0, 1);
    step(1, 1);
    step(0, 1);
    // R2 / R7: fill across the low margin
    for (int i = 0; i < 12; i++) step(1, 0);
    for (int i = 0; i < 5; i++) step(0, 1);
    // R5: paired transfers hold the count
    for (int i = 0; i < 6; i++) step(1, 1);
    // fill to full, crossing the high margin (R8)
    while (sb_q.size() < 64) step(1, 0);
    check("R2 full count", fill_count, 64);
    // R3: discarded push sets sticky overflow
    step(1, 0);
    check("R3 ovf set", ovf_err, 1);
    step(0, 0);
    check("R3 ovf sticky", ovf_err, 1);
    // R5: paired transfer while full
    step(1, 1);
    step(1, 1);
    check("R5 full pair", fill_count, 64);
    // drain fully, wrapping pointers
    while (sb_q.size() > 0) step(0, 1);
    step(0, 1);
    check("R4 count stays 0", fill_count, 0);
    // margin 0: low only at empty, high only at full
    water_mark = 6'd0;
    step(0, 0);
    step(1, 0);
    check("R7 margin0 lo", lo_alert, 0);
    // margin 32: both alerts at 32
    water_mark = 6'd32;
    while (sb_q.size() < 32) step(1, 0);
    check("R7 lo at 32", lo_alert, 1);
    check("R8 hi at 32", hi_alert, 1);
    step(1, 0);
    check("R7 lo above 32", lo_alert, 0);
    // R6: flush wins over push and pop, clears overflow
    while (sb_q.size() < 64) step(1, 0);
    step(1, 0);
    step(1, 1, 1);
    check("R6 count", fill_count, 0);
    check("R6 ovf", ovf_err, 0);
    // reuse after flush
    for (int i = 0; i < 3; i++) step(1, 0);
    for (int i = 0; i < 4; i++) step(0, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        misses++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule